// File: doc/BRIEF.md
# Cascadable Exactly-One Enable Pixel Multiplexer Tree

This block routes pixel words from a square array of imaging modules to a single output bus. Each first-stage node takes `FANIN` data words and `FANIN` enable lines. It forwards one word only when exactly one of its enables is high. In every other case it drives all ones and clears its valid flag. A second-stage node is built the same way. Its enable lines are the valid flags of the first-stage nodes, and its data inputs are their outputs. With the default `FANIN` of 3, nine modules are read out through four nodes.

Gating never mixes data from two modules. A node with no enable or with several enables drives a neutral all-ones word and a low valid flag. The next stage then treats that node as not selected. The first-stage nodes are purely combinational. The root node registers its data word and its valid flag together, so the tree presents a result one clock after its inputs.

Top module: `gmux_tree`

## Requirements
- R1: In a first-stage node, input i reaches the node output when enable i is the only high enable of that node. Leaf g input i uses enable bit `en_i[g*FANIN+i]` and data slice `dat_i[(g*FANIN+i)*WIDTH +: WIDTH]`.
- R2: A node whose enables are all low drives an all-ones word and a low valid flag.
- R3: A node with two or more enables high at once drives an all-ones word and a low valid flag, whatever its data inputs hold.
- R4: Each node gates every unselected input to all ones and merges the gated words with a bitwise AND. The selected word therefore appears unchanged, including its zero bits.
- R5: First-stage node g drives root enable g and root data input g. When the root selects node g, `dat_o` equals the word that node g forwards.
- R6: `vld_o` is high exactly when precisely one first-stage node has precisely one enable high.
- R7: Whenever `vld_o` is low, every bit of `dat_o` is 1.
- R8: `dat_o` and `vld_o` change only at a rising clock edge. They reflect the inputs present at the previous edge, which gives one cycle of latency.
- R9: While `rst_n` is low, `vld_o` is 0 and `dat_o` is all ones, whatever the enables and data hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the root output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | FANIN*FANIN | Per-module enable lines, grouped by first-stage node |
| dat_i | input | FANIN*FANIN*WIDTH | Per-module pixel words, packed in the same order as `en_i` |
| dat_o | output | WIDTH | Selected pixel word, or all ones when nothing is selected |
| vld_o | output | 1 | High when exactly one module path is selected through the tree |

## Verification
The checker assumes that the enables and data settle before each rising edge. It also assumes they change only at the falling edge, so the registered root samples each input pattern exactly once. The bench drives every input at the falling clock edge and holds it for a full period. It sweeps all enable patterns with several data seeds, so the checker's one-cycle relations always see a stable pattern at each edge. Reset is released at a falling edge. The assertions that look one cycle back also require that reset was already inactive in the cycle before.

// File: rtl/gmux_pkg.sv
`timescale 1ns/1ps
package gmux_pkg;

    // True when exactly one bit of v is set.
    function automatic logic exactly_one(input logic [31:0] v);
        return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
    endfunction

endpackage

// File: rtl/gmux_decode.sv
`timescale 1ns/1ps
module gmux_decode #(
    parameter int FANIN = 3
) (
    input  logic [FANIN-1:0] en_i,
    output logic [FANIN-1:0] sel_o,
    output logic             vld_o
);
    logic solo;

    always_comb begin
        solo  = gmux_pkg::exactly_one(32'(en_i));
        sel_o = en_i & {FANIN{solo}};
        vld_o = solo;
    end
endmodule

// File: rtl/gmux_gate.sv
`timescale 1ns/1ps
module gmux_gate #(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0] dat_i,
    input  logic             sel_i,
    output logic [WIDTH-1:0] dat_o
);
    // An unselected input becomes neutral for the AND merge.
    always_comb dat_o = sel_i ? dat_i : {WIDTH{1'b1}};
endmodule

// File: rtl/gmux_node.sv
`timescale 1ns/1ps
module gmux_node #(
    parameter int WIDTH   = 12,
    parameter int FANIN   = 3,
    parameter bit OUT_REG = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [FANIN-1:0]       en_i,
    input  logic [FANIN*WIDTH-1:0] dat_i,
    output logic [WIDTH-1:0]       dat_o,
    output logic                   vld_o
);
    typedef struct packed {
        logic [WIDTH-1:0] dat;
        logic             vld;
    } node_s;

    logic [FANIN-1:0]       sel;
    logic                   solo;
    logic [FANIN*WIDTH-1:0] gated;
    node_s                  st_d;
    node_s                  st_q;

    gmux_decode #(.FANIN(FANIN)) dec_i (
        .en_i  (en_i),
        .sel_o (sel),
        .vld_o (solo)
    );

    for (genvar i = 0; i < FANIN; i++) begin : g_gate
        gmux_gate #(.WIDTH(WIDTH)) gate_i (
            .dat_i (dat_i[i*WIDTH +: WIDTH]),
            .sel_i (sel[i]),
            .dat_o (gated[i*WIDTH +: WIDTH])
        );
    end

    always_comb begin
        st_d.dat = {WIDTH{1'b1}};
        for (int i = 0; i < FANIN; i++) begin
            st_d.dat = st_d.dat & gated[i*WIDTH +: WIDTH];
        end
        st_d.vld = solo;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '{dat: {WIDTH{1'b1}}, vld: 1'b0};
            end else begin
                st_q <= st_d;
            end
        end
    end else begin : g_comb
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst_n;
        assign st_q = st_d;
    end

    assign dat_o = st_q.dat;
    assign vld_o = st_q.vld;
endmodule

// File: rtl/gmux_tree.sv
`timescale 1ns/1ps
module gmux_tree #(
    parameter int WIDTH    = 12,
    parameter int FANIN    = 3,
    parameter bit LEAF_REG = 1'b0,
    parameter bit ROOT_REG = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [FANIN*FANIN-1:0]       en_i,
    input  logic [FANIN*FANIN*WIDTH-1:0] dat_i,
    output logic [WIDTH-1:0]             dat_o,
    output logic                         vld_o
);
    localparam int LEAF_BUS = FANIN * WIDTH;

    logic [FANIN*WIDTH-1:0] grp_dat;
    logic [FANIN-1:0]       grp_vld;

    for (genvar g = 0; g < FANIN; g++) begin : g_leaf
        gmux_node #(
            .WIDTH   (WIDTH),
            .FANIN   (FANIN),
            .OUT_REG (LEAF_REG)
        ) leaf_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (en_i[g*FANIN +: FANIN]),
            .dat_i (dat_i[g*LEAF_BUS +: LEAF_BUS]),
            .dat_o (grp_dat[g*WIDTH +: WIDTH]),
            .vld_o (grp_vld[g])
        );
    end

    gmux_node #(
        .WIDTH   (WIDTH),
        .FANIN   (FANIN),
        .OUT_REG (ROOT_REG)
    ) root_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (grp_vld),
        .dat_i (grp_dat),
        .dat_o (dat_o),
        .vld_o (vld_o)
    );
endmodule

// File: rtl/gmux_tree_chk.sv
`timescale 1ns/1ps
module gmux_tree_chk #(
    parameter int WIDTH    = 12,
    parameter int FANIN    = 3,
    parameter bit ROOT_REG = 1'b1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [FANIN*FANIN-1:0]       en_i,
    input logic [FANIN*FANIN*WIDTH-1:0] dat_i,
    input logic [FANIN*WIDTH-1:0]       grp_dat,
    input logic [FANIN-1:0]             grp_vld,
    input logic [WIDTH-1:0]             dat_o,
    input logic                         vld_o
);
    for (genvar g = 0; g < FANIN; g++) begin : g_grp
        // R3
        leaf_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grp_vld[g] |-> $countones(en_i[g*FANIN +: FANIN]) == 1);
        // R2
        leaf_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en_i[g*FANIN +: FANIN] == '0) |-> (!grp_vld[g] && (&grp_dat[g*WIDTH +: WIDTH])));
        for (genvar i = 0; i < FANIN; i++) begin : g_in
            // R1
            leaf_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (grp_vld[g] && en_i[g*FANIN+i]) |->
                (grp_dat[g*WIDTH +: WIDTH] == dat_i[(g*FANIN+i)*WIDTH +: WIDTH]));
        end
        if (ROOT_REG) begin : g_rd
            // R5
            root_dat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && vld_o && $past(grp_vld[g])) |->
                (dat_o == $past(grp_dat[g*WIDTH +: WIDTH])));
        end else begin : g_cd
            // R5
            root_dat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (vld_o && grp_vld[g]) |-> (dat_o == grp_dat[g*WIDTH +: WIDTH]));
        end
    end

    if (ROOT_REG) begin : g_rv
        // R6
        root_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (vld_o == ($countones($past(grp_vld)) == 1)));
    end else begin : g_cv
        // R6
        root_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
            vld_o == ($countones(grp_vld) == 1));
    end

    // R7
    idle_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> (&dat_o));
endmodule

bind gmux_tree gmux_tree_chk #(
    .WIDTH    (WIDTH),
    .FANIN    (FANIN),
    .ROOT_REG (ROOT_REG)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .dat_i   (dat_i),
    .grp_dat (grp_dat),
    .grp_vld (grp_vld),
    .dat_o   (dat_o),
    .vld_o   (vld_o)
);

// File: tb/gmux_tree_tb.sv
`timescale 1ns/1ps
module gmux_tree_tb_top;
    localparam int W  = 12;
    localparam int F  = 3;
    localparam int L  = F * F;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [L-1:0]   en = '0;
    logic [L*W-1:0] dat = '0;
    logic [W-1:0]   dat_o;
    logic           vld_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gmux_tree #(.WIDTH(W), .FANIN(F), .LEAF_REG(1'b0), .ROOT_REG(1'b1)) dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en),
        .dat_i (dat),
        .dat_o (dat_o),
        .vld_o (vld_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements.
    task automatic model(input logic [L-1:0] e, input logic [L*W-1:0] d,
                         output logic [W-1:0] xd, output logic xv);
        int good = 0;
        int pick = 0;
        int hit  = 0;
        for (int g = 0; g < F; g++) begin
            int cnt = 0;
            for (int i = 0; i < F; i++) begin
                if (e[g*F+i]) begin
                    cnt++;
                    hit = g*F + i;
                end
            end
            if (cnt == 1) begin
                good++;
                pick = hit;
            end
        end
        xv = (good == 1);
        xd = xv ? d[pick*W +: W] : ONES;
    endtask

    task automatic fill(input int seed);
        for (int m = 0; m < L; m++) begin
            dat[m*W +: W] = W'((m * 467 + seed * 695 + 241) % 4095);
        end
    endtask

    task automatic apply_check(input logic [L-1:0] e, input string tv, input string td);
        logic [W-1:0] xd;
        logic         xv;
        en = e;
        model(e, dat, xd, xv);
        @(negedge clk);
        check(tv, 32'(vld_o), 32'(xv));
        check(td, 32'(dat_o), 32'(xd));
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] xd;
        logic         xv;
        fill(1);
        en = 9'b000_000_010;
        repeat (3) @(negedge clk);
        // R9: reset dominates a valid selection
        check("R9", 32'(vld_o), 32'd0);
        check("R9", 32'(dat_o), 32'(ONES));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'(vld_o), 32'd1);
        check("R1", 32'(dat_o), 32'(dat[1*W +: W]));

        // R8: new inputs are not visible before the next rising edge
        en = 9'b000_100_000;
        #5;
        check("R8", 32'(dat_o), 32'(dat[1*W +: W]));
        @(negedge clk);
        check("R8", 32'(dat_o), 32'(dat[5*W +: W]));

        // R2: no enable at all
        apply_check(9'b000_000_000, "R2", "R2");

        // R3: two enables in one node, with no other node selected
        apply_check(9'b011_000_000, "R3", "R3");
        apply_check(9'b111_000_000, "R3", "R3");

        // R4: zero bits of the selected word survive the merge
        dat = {L*W{1'b1}};
        dat[4*W +: W] = 12'hA5A;
        apply_check(9'b000_010_000, "R4", "R4");
        dat[4*W +: W] = 12'h000;
        apply_check(9'b000_010_000, "R4", "R4");

        // R5: a bad node next to a good node lets the good one through
        fill(2);
        apply_check(9'b110_000_100, "R6", "R5");
        // R6: two good nodes cancel each other
        apply_check(9'b100_000_001, "R6", "R7");

        // Exhaustive enable sweep over several data seeds
        for (int s = 3; s < 6; s++) begin
            fill(s);
            for (int p = 0; p < (1 << L); p++) begin
                model(L'(p), dat, xd, xv);
                apply_check(L'(p), xv ? "R6" : "R3", xv ? "R5" : "R7");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule